// File: doc/BRIEF.md
# Sync-Driven Slot and Integration Timer

This block produces the timing strobes for a slotted, periodic measurement. A slot begins on a sync. The sync can come from the `sync_i` pin, or from an internal generator that repeats at a programmed slot period. After the sync, the timer waits a programmed delay. It then runs a programmed number of integration windows of equal length, back to back, and goes idle until the next sync.

Every interval is counted in ticks. A mode input chooses whether a tick is every clock or only a clock with an input-sample enable. All length fields are loaded as the wanted value minus one.

A separate update-enable flag tells downstream logic when it may start applying changes. It can be set by a write pulse, or armed so that the next external sync sets it. A master enable stops all timing when it is low. A synchronous clear returns everything to the idle state.

Top module: `sync_slot_timer`

## Requirements
- R1: While enabled and not cleared, an external sync sampled on a clock edge makes `slot_start_o` high for exactly the following cycle, whatever the tick source.
- R2: The first window begins D = `cfg_delay_m1_i`+1 ticks after the sync edge; `win_start_o` rises on the edge of the D-th tick.
- R3: A slot holds N = `cfg_nwin_m1_i`+1 windows of L = `cfg_len_m1_i`+1 ticks each. Window j (counting from 0) starts at tick D+j·L and ends at tick D+(j+1)·L. Each end strobe coincides with the next window's start strobe. `win_active_o` is high from the first start strobe up to the cycle before the last end strobe. After the last end strobe the timer stays idle until a sync.
- R4: With `cfg_count_clocks_i`=1 every clock is a tick. With `cfg_count_clocks_i`=0 a tick is a clock in which `sample_en_i`=1, and cycles without it advance nothing.
- R5: With `cfg_self_sync_i`=1, an internal sync occurs every P = `cfg_period_m1_i`+1 ticks. An external sync restarts this period count, so the next internal sync is P ticks after it.
- R6: A sync that arrives during the delay or inside a window restarts the delay from zero. It abandons the current window, and no end strobe is given for that window.
- R7: With `cfg_enable_i`=0 the timer is idle and all its counters are cleared. It emits no strobe, `win_active_o` is low, and syncs are ignored, including for the update flag.
- R8: `upd_en_o` is set by `upd_set_i`, or by an enabled external sync while `upd_arm_i`=1. It is cleared by `upd_clr_i`, and a clear wins over a set in the same cycle. It keeps its value otherwise.
- R9: `clr_i`=1 makes every strobe, `win_active_o` and `upd_en_o` zero in the next cycle. The timer stays idle afterwards until a new sync.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of all state |
| cfg_enable_i | input | 1 | Master enable for timers and syncs |
| cfg_count_clocks_i | input | 1 | 1: count clocks, 0: count sample enables |
| cfg_self_sync_i | input | 1 | Enables the internal slot-period sync generator |
| cfg_period_m1_i | input | 16 | Slot period minus one |
| cfg_delay_m1_i | input | 16 | Sync-to-first-window delay minus one |
| cfg_nwin_m1_i | input | 15 | Windows per slot minus one |
| cfg_len_m1_i | input | 16 | Window length minus one |
| sample_en_i | input | 1 | Input-sample enable |
| sync_i | input | 1 | External sync pulse |
| upd_set_i | input | 1 | Write pulse setting the update flag |
| upd_clr_i | input | 1 | Write pulse clearing the update flag |
| upd_arm_i | input | 1 | Lets the next external sync set the update flag |
| slot_start_o | output | 1 | One-cycle strobe at each accepted sync |
| win_start_o | output | 1 | One-cycle strobe at each window start |
| win_end_o | output | 1 | One-cycle strobe at each completed window end |
| win_active_o | output | 1 | High while a window is running |
| upd_en_o | output | 1 | Update-enable flag |

## Verification
Every output is a register. An event caused by an input sampled on edge e shows up after edge e, and the bench reads it at the following falling edge. Timing is measured in edges after the sync edge. `slot_start_o` is due at offset 0. Start and end strobes are due at offsets s·(D+j·L) and s·(D+(j+1)·L), where s is 1 in clock mode. In sample mode s is 3, because the bench raises `sample_en_i` on every third edge. When a resync or an internal sync at P occurs, the offset is taken from that most recent sync. Every cycle of each run is compared against these formulas, and the update flag and the clear are due one cycle after their pulse.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    SST_IDLE  = 2'd0,
    SST_DELAY = 2'd1,
    SST_WIN   = 2'd2
  } sst_state_e;

endpackage

// File: rtl/sst_rst_sync.sv
module sst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sst_period_gen.sv
module sst_period_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic             ext_sync,
  input  logic [CNT_W-1:0] period_m1,
  output logic             int_sync
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap     = run && tick && (cnt_q == period_m1);
  assign int_sync = wrap && !ext_sync && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run || ext_sync) begin
      cnt_d = '0;
    end else if (tick) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sst_sequencer.sv
module sst_sequencer
  import sst_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NWIN_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enable,
  input  logic              tick,
  input  logic              sync,
  input  logic [CNT_W-1:0]  delay_m1,
  input  logic [CNT_W-1:0]  len_m1,
  input  logic [NWIN_W-1:0] nwin_m1,
  output logic              slot_start,
  output logic              win_start,
  output logic              win_end,
  output logic              win_active
);

  sst_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NWIN_W-1:0] wnum_q, wnum_d;
  logic              ss_q, ss_d, ws_q, ws_d, we_q, we_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wnum_d  = wnum_q;
    ss_d    = 1'b0;
    ws_d    = 1'b0;
    we_d    = 1'b0;
    if (clr || !enable) begin
      state_d = SST_IDLE;
      cnt_d   = '0;
      wnum_d  = '0;
    end else if (sync) begin
      state_d = SST_DELAY;
      cnt_d   = '0;
      wnum_d  = '0;
      ss_d    = 1'b1;
    end else if (tick) begin
      unique case (state_q)
        SST_DELAY: begin
          if (cnt_q == delay_m1) begin
            state_d = SST_WIN;
            cnt_d   = '0;
            wnum_d  = '0;
            ws_d    = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SST_WIN: begin
          if (cnt_q == len_m1) begin
            we_d  = 1'b1;
            cnt_d = '0;
            if (wnum_q == nwin_m1) begin
              state_d = SST_IDLE;
              wnum_d  = '0;
            end else begin
              wnum_d = wnum_q + 1'b1;
              ws_d   = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = SST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SST_IDLE;
      cnt_q   <= '0;
      wnum_q  <= '0;
      ss_q    <= 1'b0;
      ws_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wnum_q  <= wnum_d;
      ss_q    <= ss_d;
      ws_q    <= ws_d;
      we_q    <= we_d;
    end
  end

  assign slot_start = ss_q;
  assign win_start  = ws_q;
  assign win_end    = we_q;
  assign win_active = (state_q == SST_WIN);

endmodule

// File: rtl/sst_update_flag.sv
module sst_update_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_wr,
  input  logic clr_wr,
  input  logic arm,
  input  logic ext_sync,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr || clr_wr)                  flag_d = 1'b0;
    else if (set_wr || (arm && ext_sync)) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/sync_slot_timer.sv
module sync_slot_timer #(
  parameter int CNT_W  = 16,
  parameter int NWIN_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cfg_enable_i,
  input  logic              cfg_count_clocks_i,
  input  logic              cfg_self_sync_i,
  input  logic [CNT_W-1:0]  cfg_period_m1_i,
  input  logic [CNT_W-1:0]  cfg_delay_m1_i,
  input  logic [NWIN_W-1:0] cfg_nwin_m1_i,
  input  logic [CNT_W-1:0]  cfg_len_m1_i,
  input  logic              sample_en_i,
  input  logic              sync_i,
  input  logic              upd_set_i,
  input  logic              upd_clr_i,
  input  logic              upd_arm_i,
  output logic              slot_start_o,
  output logic              win_start_o,
  output logic              win_end_o,
  output logic              win_active_o,
  output logic              upd_en_o
);

  logic rst_n_sync;
  logic tick;
  logic ext_sync;
  logic int_sync;
  logic any_sync;

  sst_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // clock enable for every counter in the block
  assign tick     = cfg_enable_i && (cfg_count_clocks_i || sample_en_i);
  assign ext_sync = cfg_enable_i && sync_i && !clr_i;
  assign any_sync = ext_sync || int_sync;

  sst_period_gen #(.CNT_W(CNT_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clr       (clr_i),
    .run       (cfg_enable_i && cfg_self_sync_i),
    .tick      (tick),
    .ext_sync  (ext_sync),
    .period_m1 (cfg_period_m1_i),
    .int_sync  (int_sync)
  );

  sst_sequencer #(.CNT_W(CNT_W), .NWIN_W(NWIN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .clr        (clr_i),
    .enable     (cfg_enable_i),
    .tick       (tick),
    .sync       (any_sync),
    .delay_m1   (cfg_delay_m1_i),
    .len_m1     (cfg_len_m1_i),
    .nwin_m1    (cfg_nwin_m1_i),
    .slot_start (slot_start_o),
    .win_start  (win_start_o),
    .win_end    (win_end_o),
    .win_active (win_active_o)
  );

  sst_update_flag u_upd (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .clr      (clr_i),
    .set_wr   (upd_set_i),
    .clr_wr   (upd_clr_i),
    .arm      (upd_arm_i),
    .ext_sync (ext_sync),
    .flag     (upd_en_o)
  );

endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic clk,
  input logic rst_n,
  input logic clr_i,
  input logic cfg_enable_i,
  input logic cfg_count_clocks_i,
  input logic sample_en_i,
  input logic sync_i,
  input logic upd_set_i,
  input logic upd_clr_i,
  input logic slot_start_o,
  input logic win_start_o,
  input logic win_end_o,
  input logic win_active_o,
  input logic upd_en_o
);

  assert_sync_starts_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && cfg_enable_i && !clr_i) |=> slot_start_o);

  assert_end_inside_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_o |-> $past(win_active_o));

  assert_start_opens_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_o |-> win_active_o);

  assert_no_tick_no_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_count_clocks_i && !sample_en_i && !sync_i) |=>
      (!slot_start_o && !win_start_o && !win_end_o));

  assert_resync_drops_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start_o |-> (!win_end_o && !win_start_o && !win_active_o));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable_i |=> (!slot_start_o && !win_start_o && !win_end_o && !win_active_o));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_set_i && !upd_clr_i && !clr_i) |=> upd_en_o);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_clr_i |=> !upd_en_o);

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!slot_start_o && !win_start_o && !win_end_o && !win_active_o && !upd_en_o));

endmodule

bind sync_slot_timer sst_checker u_sst_checker (
  .clk                (clk),
  .rst_n              (rst_n_sync),
  .clr_i              (clr_i),
  .cfg_enable_i       (cfg_enable_i),
  .cfg_count_clocks_i (cfg_count_clocks_i),
  .sample_en_i        (sample_en_i),
  .sync_i             (sync_i),
  .upd_set_i          (upd_set_i),
  .upd_clr_i          (upd_clr_i),
  .slot_start_o       (slot_start_o),
  .win_start_o        (win_start_o),
  .win_end_o          (win_end_o),
  .win_active_o       (win_active_o),
  .upd_en_o           (upd_en_o)
);

// File: tb/sync_slot_timer_tb.sv
`timescale 1ns/1ps
module sync_slot_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i, cfg_enable_i, cfg_count_clocks_i, cfg_self_sync_i;
  logic [15:0] cfg_period_m1_i, cfg_delay_m1_i, cfg_len_m1_i;
  logic [14:0] cfg_nwin_m1_i;
  logic        sample_en_i, sync_i, upd_set_i, upd_clr_i, upd_arm_i;
  logic        slot_start_o, win_start_o, win_end_o, win_active_o, upd_en_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sync_slot_timer u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cfg_enable_i(cfg_enable_i),
    .cfg_count_clocks_i(cfg_count_clocks_i), .cfg_self_sync_i(cfg_self_sync_i),
    .cfg_period_m1_i(cfg_period_m1_i), .cfg_delay_m1_i(cfg_delay_m1_i),
    .cfg_nwin_m1_i(cfg_nwin_m1_i), .cfg_len_m1_i(cfg_len_m1_i),
    .sample_en_i(sample_en_i), .sync_i(sync_i), .upd_set_i(upd_set_i),
    .upd_clr_i(upd_clr_i), .upd_arm_i(upd_arm_i),
    .slot_start_o(slot_start_o), .win_start_o(win_start_o), .win_end_o(win_end_o),
    .win_active_o(win_active_o), .upd_en_o(upd_en_o)
  );

  function automatic logic [4:0] outs();
    return {slot_start_o, win_start_o, win_end_o, win_active_o, upd_en_o};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b (slot,ws,we,act,upd)", req, $time, act, exp);
    end
  endtask

  // expected {slot,ws,we,active} at offset i after the latest sync; ticks every s edges
  function automatic logic [3:0] exp_at(int i, int s, int d, int l, int n);
    logic sl, ws, we, ac;
    int t;
    sl = (i == 0);
    ws = 1'b0;
    we = 1'b0;
    ac = (i >= s * d) && (i < s * (d + n * l));
    if (i % s == 0) begin
      t = i / s;
      if (t >= d && ((t - d) % l) == 0) begin
        ws = ((t - d) / l) < n;
        we = (t > d) && (((t - d) / l) <= n);
      end
    end
    return {sl, ws, we, ac};
  endfunction

  task automatic run(string req, bit cc, int d, int l, int n, int rs, int p);
    int s, h, base;
    s = cc ? 1 : 3;
    @(negedge clk);
    cfg_enable_i       = 1'b0;
    cfg_count_clocks_i = cc;
    cfg_self_sync_i    = (p > 0);
    cfg_period_m1_i    = 16'(p - 1);
    cfg_delay_m1_i     = 16'(d - 1);
    cfg_len_m1_i       = 16'(l - 1);
    cfg_nwin_m1_i      = 15'(n - 1);
    sample_en_i        = 1'b0;
    @(negedge clk);
    cfg_enable_i = 1'b1;
    sync_i       = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    h = s * (d + n * l) + 4 + rs;
    if (p > 0) h = 3 * p + 2;
    for (int i = 0; i <= h; i++) begin
      base = 0;
      if (p > 0) base = (i / p) * p;
      if (rs > 0 && i >= rs) base = rs;
      check(req, outs(), {exp_at(i - base, s, d, l, n), 1'b0});
      sample_en_i = !cc && (((i + 1) % 3) == 0);
      sync_i      = (rs > 0) && (i + 1 == rs);
      @(negedge clk);
    end
    sync_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clr_i = 0; cfg_enable_i = 0; cfg_count_clocks_i = 1; cfg_self_sync_i = 0;
    cfg_period_m1_i = 0; cfg_delay_m1_i = 0; cfg_len_m1_i = 0; cfg_nwin_m1_i = 0;
    sample_en_i = 0; sync_i = 0; upd_set_i = 0; upd_clr_i = 0; upd_arm_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset", outs(), 5'b0);

    // R1 R2 R3: clock-mode sweep
    for (int d = 1; d <= 3; d++)
      for (int l = 1; l <= 3; l++)
        for (int n = 1; n <= 3; n++)
          run("R1 R2 R3 clock", 1'b1, d, l, n, 0, 0);

    // R4: sample-enable mode, ticks every third edge
    for (int d = 1; d <= 2; d++)
      for (int l = 1; l <= 3; l += 2)
        for (int n = 1; n <= 2; n++)
          run("R4 sample", 1'b0, d, l, n, 0, 0);

    // R6: resync inside a window and inside the delay
    run("R6 resync window", 1'b1, 3, 4, 2, 5, 0);
    run("R6 resync delay", 1'b1, 3, 2, 2, 2, 0);

    // R5: internal syncs, long period, truncating period, minimum period
    run("R5 period long", 1'b1, 2, 3, 2, 0, 20);
    run("R5 period short", 1'b1, 2, 2, 3, 0, 5);
    run("R5 period min", 1'b1, 1, 1, 1, 0, 2);

    // R4: sample mode without any sample enable: nothing after slot start
    @(negedge clk);
    cfg_enable_i = 0; cfg_self_sync_i = 0; cfg_count_clocks_i = 0;
    cfg_delay_m1_i = 0; cfg_len_m1_i = 0; cfg_nwin_m1_i = 0; sample_en_i = 0;
    @(negedge clk);
    cfg_enable_i = 1; sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    check("R4 slot without ticks", outs(), 5'b10000);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R4 stalled", outs(), 5'b00000);
    end

    // R7: disabled, syncs and arming ignored
    cfg_enable_i = 0; cfg_count_clocks_i = 1; upd_arm_i = 1;
    for (int i = 0; i < 4; i++) begin
      sync_i = 1;
      @(negedge clk);
      check("R7 disabled", outs(), 5'b00000);
    end
    sync_i = 0; upd_arm_i = 0;

    // R7: disable mid-window, re-enable without sync stays idle
    cfg_delay_m1_i = 0; cfg_len_m1_i = 7; cfg_nwin_m1_i = 0;
    cfg_enable_i = 1; sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    repeat (3) @(negedge clk);
    check("R7 window running", outs(), 5'b00010);
    cfg_enable_i = 0;
    @(negedge clk);
    check("R7 disable stops", outs(), 5'b00000);
    cfg_enable_i = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R7 idle after re-enable", outs(), 5'b00000);
    end

    // R8: update flag
    upd_set_i = 1;
    @(negedge clk);
    upd_set_i = 0;
    check("R8 set", outs(), 5'b00001);
    @(negedge clk);
    check("R8 hold", outs(), 5'b00001);
    upd_set_i = 1; upd_clr_i = 1;
    @(negedge clk);
    upd_set_i = 0; upd_clr_i = 0;
    check("R8 clear wins", outs(), 5'b00000);
    cfg_len_m1_i = 0; cfg_delay_m1_i = 15;
    sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    check("R8 unarmed sync", outs(), 5'b10000);
    upd_arm_i = 1; sync_i = 1;
    @(negedge clk);
    sync_i = 0; upd_arm_i = 0;
    check("R8 armed sync", outs(), 5'b10001);

    // R9: synchronous clear mid-sequence
    cfg_delay_m1_i = 0; cfg_len_m1_i = 9; cfg_nwin_m1_i = 2;
    sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    repeat (3) @(negedge clk);
    check("R9 before clear", outs(), 5'b00011);
    clr_i = 1;
    @(negedge clk);
    clr_i = 0;
    check("R9 cleared", outs(), 5'b00000);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R9 idle after clear", outs(), 5'b00000);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule